// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a serial EEPROM that sits on a three-wire bus with chip select, serial clock and serial data in, plus a serial data out with its own enable. All pins are sampled in the system clock domain. The serial clock's rising edge is found by comparing the pin with its value one system clock earlier. A 2 Kbit register array is held as 128 words of 16 bits. An organization input chooses between 16-bit words with 7-bit addresses and 8-bit bytes with 8-bit addresses.

A transaction opens with a start bit. A 2-bit opcode follows, then the address and, where the command needs it, the data, each field sent MSB first. Reads stream data out continuously with an auto-incrementing address. Writes and erases stay pending until chip select falls. Programming then runs for a fixed number of system clocks, and the host can poll progress on data out. Programming is locked after reset and must be unlocked by command.

Top module: `uw_eeprom`

## Requirements
- R1: A start bit is taken on the first serial-clock rising edge at which chip select and data in are both high. Edges with data in low while chip select is high, and any pin activity while chip select is low, start nothing.
- R2: The start bit is followed by opcode bits {b1,b0}: 10 reads, 01 writes, 11 erases, 00 is an extended command. For an extended command the two MSBs of the address field select: 11 unlock, 00 lock, 01 write-all (data follows), 10 erase-all.
- R3: With org_i high, the address field is 7 bits and words are 16 bits. With org_i low, the address field is 8 bits and words are 8 bits.
- R4: A read drives data out to 0 (a dummy bit) on the rising edge that takes the last address bit. Each following rising edge then presents the next data bit, MSB first. After the last bit of a word, output continues with the next address and wraps from the top of the array to address 0.
- R5: The data-out enable is low one system clock after chip select is seen low. It is also low while chip select is high with no read and no status pending.
- R6: A complete write, erase, write-all or erase-all starts programming on the next fall of chip select. While chip select is high, data out is then enabled and low for PROG_CYCLES system clocks and high once programming has finished.
- R7: After reset, programming is locked and every array bit reads 1. A write or erase issued while locked leaves the array unchanged and reports no status.
- R8: The unlock command permits write, erase, write-all and erase-all. The lock command blocks all four again.
- R9: A write stores its data word at the address given. An erase sets the addressed word to all ones.
- R10: Write-all stores its data in every word. Erase-all sets every word to all ones.
- R11: If chip select falls before every bit a command needs has been received, the command is discarded.
- R12: While programming is in progress, a start bit is ignored and no command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects 8-bit words |
| dout_o | output | 1 | Serial data out, or ready (1) / busy (0) status |
| dout_oe_o | output | 1 | Data out enable; low means high impedance |

## Verification
Every cycle, the assertions check the following. The output enable goes off after deselect. Nothing is programmed unless the array is unlocked. Data out reads low whenever it is enabled during programming. The first read cycle shows the dummy zero. The command machine stays idle for the whole busy window. Only the bench's scenarios can show the rest, because each of these needs a full serial transaction followed by a read-back: the data values and their bit order, sequential reads that wrap at both organizations, the opcode and extended-code decode, the effect of lock and unlock, discarded short commands, and commands ignored while busy.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_WRALL  = 2'b01,
    EX_ERALL  = 2'b10,
    EX_UNLOCK = 2'b11
  } ext_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/uw_sclk_edge.sv
module uw_sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
endmodule

// File: rtl/uw_prog_timer.sv
module uw_prog_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uw_mem.sv
module uw_mem #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          org_i,
  input  logic          wr_i,
  input  logic          wr_all_i,
  input  logic [AW:0]   wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW:0]   rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned WORDS = 1 << AW;
  localparam int unsigned HW    = DW / 2;

  logic [DW-1:0] words [WORDS];

  // x8: byte at even address lives in the low half of the word
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic sel, hi_en, lo_en;
    logic [HW-1:0] hi_d;
    logic [DW-1:0] word_q;

    assign sel   = wr_all_i |
                   (org_i ? (wr_addr_i[AW-1:0] == AW'(i)) : (wr_addr_i[AW:1] == AW'(i)));
    assign hi_en = sel & (org_i | wr_all_i |  wr_addr_i[0]);
    assign lo_en = sel & (org_i | wr_all_i | ~wr_addr_i[0]);
    assign hi_d  = org_i ? wr_data_i[DW-1:HW] : wr_data_i[HW-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (wr_i) begin
        if (hi_en) word_q[DW-1:HW] <= hi_d;
        if (lo_en) word_q[HW-1:0]  <= wr_data_i[HW-1:0];
      end
    end

    assign words[i] = word_q;
  end

  logic [DW-1:0] byte_word;
  assign byte_word = words[rd_addr_i[AW:1]];

  always_comb begin
    if (org_i)              rd_data_o = words[rd_addr_i[AW-1:0]];
    else if (rd_addr_i[0])  rd_data_o = {{HW{1'b0}}, byte_word[DW-1:HW]};
    else                    rd_data_o = {{HW{1'b0}}, byte_word[HW-1:0]};
  end
endmodule

// File: rtl/uw_cmd_ctrl.sv
module uw_cmd_ctrl
  import uw_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          di_i,
  input  logic          org_i,
  input  logic          rise_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [AW:0]   rd_addr_o,
  output logic          prog_o,
  output logic          prog_all_o,
  output logic [AW:0]   prog_addr_o,
  output logic [DW-1:0] prog_data_o,
  output logic          dout_o,
  output logic          dout_oe_o,
  output st_e           state_o,
  output logic          we_o
);
  localparam int unsigned AW8 = AW + 1;
  localparam int unsigned HW  = DW / 2;
  localparam int unsigned CW  = $clog2(2 + AW8 + DW + 1);
  localparam int unsigned BW  = $clog2(DW);

  st_e            state_q;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [1:0]     op_q, op_n;
  logic [AW8-1:0] addr_q, addr_n, addr_m;
  logic [DW-1:0]  data_q, data_n;
  logic           we_q, pend_q, prog_go_q, stat_q;
  logic           dout_q, oe_q;
  logic [AW8-1:0] rd_addr_q, rd_addr_inc;
  logic [BW-1:0]  rd_cnt_q, top_bit;
  logic           prog_all_q;
  logic [AW8-1:0] prog_addr_q;
  logic [DW-1:0]  prog_data_q;

  logic           x8;
  logic [CW-1:0]  aw, dw, hdr, need;
  logic [1:0]     top2;
  logic           needs_data, done;

  assign x8  = ~org_i;
  assign aw  = x8 ? CW'(AW8) : CW'(AW);
  assign dw  = x8 ? CW'(HW)  : CW'(DW);
  assign hdr = CW'(2) + aw;

  always_comb begin
    op_n   = op_q;
    addr_n = addr_q;
    data_n = data_q;
    if (cnt_q < CW'(2))  op_n   = {op_q[0], di_i};
    else if (cnt_q < hdr) addr_n = {addr_q[AW8-2:0], di_i};
    else                  data_n = {data_q[DW-2:0], di_i};
    cnt_n      = cnt_q + 1'b1;
    top2       = x8 ? addr_n[AW8-1:AW8-2] : addr_n[AW-1:AW-2];
    needs_data = (op_n == OP_WRITE) || ((op_n == OP_EXT) && (top2 == EX_WRALL));
    need       = hdr + (needs_data ? dw : CW'(0));
    done       = (cnt_n >= hdr) && (cnt_n == need);
    addr_m     = x8 ? addr_n : {1'b0, addr_n[AW-1:0]};
  end

  assign top_bit = x8 ? BW'(HW - 1) : BW'(DW - 1);

  always_comb begin
    rd_addr_inc = rd_addr_q + 1'b1;
    if (!x8) rd_addr_inc[AW] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      we_q        <= 1'b0;
      pend_q      <= 1'b0;
      prog_go_q   <= 1'b0;
      stat_q      <= 1'b0;
      dout_q      <= 1'b0;
      oe_q        <= 1'b0;
      rd_addr_q   <= '0;
      rd_cnt_q    <= '0;
      prog_all_q  <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else begin
      prog_go_q <= 1'b0;
      if (!cs_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        if (pend_q) begin
          pend_q    <= 1'b0;
          prog_go_q <= 1'b1;
          stat_q    <= 1'b1;
        end
      end else begin
        if (state_q == ST_IDLE) begin
          oe_q   <= stat_q;
          dout_q <= ~(busy_i | prog_go_q);
        end
        if (rise_i) begin
          unique case (state_q)
            ST_IDLE: begin
              if (di_i && !busy_i && !prog_go_q) begin
                state_q <= ST_CMD;
                cnt_q   <= '0;
                op_q    <= '0;
                addr_q  <= '0;
                data_q  <= '0;
                stat_q  <= 1'b0;
                oe_q    <= 1'b0;
              end
            end
            ST_CMD: begin
              op_q   <= op_n;
              addr_q <= addr_n;
              data_q <= data_n;
              cnt_q  <= cnt_n;
              if (done) begin
                state_q <= ST_HOLD;
                unique case (op_n)
                  OP_READ: begin
                    state_q   <= ST_READ;
                    oe_q      <= 1'b1;
                    dout_q    <= 1'b0;
                    rd_addr_q <= addr_m;
                    rd_cnt_q  <= '0;
                  end
                  OP_WRITE, OP_ERASE: begin
                    if (we_q) begin
                      pend_q      <= 1'b1;
                      prog_all_q  <= 1'b0;
                      prog_addr_q <= addr_m;
                      prog_data_q <= (op_n == OP_ERASE) ? '1 : data_n;
                    end
                  end
                  default: begin
                    unique case (top2)
                      EX_LOCK:   we_q <= 1'b0;
                      EX_UNLOCK: we_q <= 1'b1;
                      default: begin
                        if (we_q) begin
                          pend_q      <= 1'b1;
                          prog_all_q  <= 1'b1;
                          prog_addr_q <= '0;
                          prog_data_q <= (top2 == EX_ERALL) ? '1 : data_n;
                        end
                      end
                    endcase
                  end
                endcase
              end
            end
            ST_READ: begin
              dout_q <= rd_word_i[top_bit - rd_cnt_q];
              if (rd_cnt_q == top_bit) begin
                rd_cnt_q  <= '0;
                rd_addr_q <= rd_addr_inc;
              end else begin
                rd_cnt_q <= rd_cnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_addr_o   = rd_addr_q;
  assign prog_o      = prog_go_q;
  assign prog_all_o  = prog_all_q;
  assign prog_addr_o = prog_addr_q;
  assign prog_data_o = prog_data_q;
  assign dout_o      = dout_q;
  assign dout_oe_o   = oe_q;
  assign state_o     = state_q;
  assign we_o        = we_q;
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
  import uw_pkg::*;
#(
  parameter int unsigned WORD_AW     = 7,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  output logic dout_o,
  output logic dout_oe_o
);
  logic                rise;
  logic                busy;
  logic                prog_go;
  logic                prog_all;
  logic [WORD_AW:0]    prog_addr;
  logic [WORD_W-1:0]   prog_data;
  logic [WORD_AW:0]    rd_addr;
  logic [WORD_W-1:0]   rd_word;
  st_e                 ctrl_state;
  logic                we_en;

  uw_sclk_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise)
  );

  uw_cmd_ctrl #(.AW(WORD_AW), .DW(WORD_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .di_i        (di_i),
    .org_i       (org_i),
    .rise_i      (rise),
    .busy_i      (busy),
    .rd_word_i   (rd_word),
    .rd_addr_o   (rd_addr),
    .prog_o      (prog_go),
    .prog_all_o  (prog_all),
    .prog_addr_o (prog_addr),
    .prog_data_o (prog_data),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .state_o     (ctrl_state),
    .we_o        (we_en)
  );

  uw_mem #(.AW(WORD_AW), .DW(WORD_W)) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .org_i     (org_i),
    .wr_i      (prog_go),
    .wr_all_i  (prog_all),
    .wr_addr_i (prog_addr),
    .wr_data_i (prog_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_word)
  );

  uw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_go),
    .busy_o  (busy)
  );
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk
  import uw_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic busy,
  input logic prog_go,
  input logic we,
  input st_e  state
);
  a_r5_oe_off_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !dout_oe_o);

  a_r7_prog_only_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go |-> we);

  a_r6_busy_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_o && busy) |-> !dout_o);

  a_r4_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_READ && !$past(state == ST_READ)) |-> (dout_oe_o && !dout_o));

  a_r12_idle_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> state == ST_IDLE);
endmodule

bind uw_eeprom uw_eeprom_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .busy      (busy),
  .prog_go   (prog_go),
  .we        (we_en),
  .state     (ctrl_state)
);

// File: tb/test_uw_eeprom.sv
module test_uw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 200;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, oe;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uw_eeprom #(.PROG_CYCLES(PROG)) i_uw_eeprom (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_i      (cs),
    .sclk_i    (sclk),
    .di_i      (di),
    .org_i     (org),
    .dout_o    (dout),
    .dout_oe_o (oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw();
    return org ? 7 : 8;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  task automatic sbit(logic b);
    sclk = 1'b0;
    di   = b;
    clk_n(4);
    sclk = 1'b1;
    clk_n(4);
  endtask

  task automatic sbits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic begin_cmd();
    cs = 1'b1;
    di = 1'b0;
    clk_n(3);
    sbit(1'b1);
  endtask

  task automatic end_cs();
    sclk = 1'b0;
    di   = 1'b0;
    clk_n(2);
    cs = 1'b0;
    clk_n(3);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [31:0] addr, logic [31:0] data, bit with_data);
    begin_cmd();
    sbits({30'd0, op}, 2);
    sbits(addr, aw());
    if (with_data) sbits(data, dw());
    end_cs();
  endtask

  task automatic send_ext(logic [1:0] code, logic [31:0] data, bit with_data);
    send_cmd(2'b00, 32'(code) << (aw() - 2), data, with_data);
  endtask

  // R6: poll status after cs fall; time in system clocks since cs fell
  task automatic prog_wait(string req);
    int k = 3;
    bit ready = 1'b0;
    cs = 1'b1;
    clk_n(1);
    k++;
    chk({req, " R6 busy status low"}, {30'd0, oe, dout}, 32'b10);
    for (int i = 0; i < 1000 && !ready; i++) begin
      clk_n(1);
      k++;
      if (dout === 1'b1) ready = 1'b1;
    end
    chk({req, " R6 ready seen"}, 32'(ready), 32'd1);
    chk({req, " R6 programming time in window"},
        32'((k >= PROG) && (k <= PROG + 6)), 32'd1);
    cs = 1'b0;
    clk_n(3);
  endtask

  task automatic read_chk(string req, logic [31:0] addr, int nw,
                          logic [15:0] e0, logic [15:0] e1);
    logic [15:0] val;
    begin_cmd();
    sbits(32'b10, 2);
    sbits(addr, aw());
    chk({req, " R4 dummy zero"}, {30'd0, oe, dout}, 32'b10);
    for (int w = 0; w < nw; w++) begin
      val = '0;
      for (int b = 0; b < dw(); b++) begin
        sbit(1'b0);
        val = {val[14:0], dout};
      end
      chk({req, " R4 read data"}, 32'(val), 32'(w == 0 ? e0 : e1));
    end
    end_cs();
    chk({req, " R5 oe off after deselect"}, 32'(oe), 32'd0);
  endtask

  task automatic t_reset();
    chk("R5 reset oe", 32'(oe), 32'd0);
    read_chk("R7 reset array ones", 32'd3, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic t_start_qual();
    logic [15:0] val = '0;
    for (int i = 0; i < 3; i++) sbit(1'b1);
    sclk = 1'b0;
    clk_n(3);
    chk("R1 no op while deselected", 32'(oe), 32'd0);
    cs = 1'b1;
    clk_n(3);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    chk("R1 zeros before start do nothing", 32'(oe), 32'd0);
    sbit(1'b1);
    sbits(32'b10, 2);
    sbits(32'd3, 7);
    chk("R1 read after leading zeros dummy", {30'd0, oe, dout}, 32'b10);
    for (int b = 0; b < 16; b++) begin
      sbit(1'b0);
      val = {val[14:0], dout};
    end
    chk("R1 read after leading zeros data", 32'(val), 32'hFFFF);
    end_cs();
  endtask

  task automatic t_protect();
    send_cmd(2'b01, 32'd5, 32'h1234, 1'b1);
    cs = 1'b1;
    clk_n(3);
    chk("R7 locked write reports no status", 32'(oe), 32'd0);
    cs = 1'b0;
    clk_n(3);
    read_chk("R7 locked write ignored", 32'd5, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic t_write_read();
    send_ext(2'b11, 32'd0, 1'b0);
    send_cmd(2'b01, 32'd5, 32'hA5C3, 1'b1);
    prog_wait("R9 write");
    read_chk("R8 R9 R2 write after unlock", 32'd5, 1, 16'hA5C3, 16'h0);
  endtask

  task automatic t_seq_wrap();
    send_cmd(2'b01, 32'd127, 32'h1234, 1'b1);
    prog_wait("R4 wrap setup");
    send_cmd(2'b01, 32'd0, 32'h0F0F, 1'b1);
    prog_wait("R4 wrap setup");
    read_chk("R4 sequential wrap x16", 32'd127, 2, 16'h1234, 16'h0F0F);
  endtask

  task automatic t_erase();
    send_cmd(2'b11, 32'd5, 32'd0, 1'b0);
    prog_wait("R9 erase");
    read_chk("R9 erase sets ones", 32'd5, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic t_trunc();
    begin_cmd();
    sbits(32'b01, 2);
    sbits(32'd6, 7);
    sbits(32'h0001, 10);
    end_cs();
    cs = 1'b1;
    clk_n(3);
    chk("R11 truncated write reports no status", 32'(oe), 32'd0);
    cs = 1'b0;
    clk_n(3);
    read_chk("R11 truncated write discarded", 32'd6, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic t_busy_block();
    send_cmd(2'b01, 32'd7, 32'h7777, 1'b1);
    begin_cmd();
    sbits(32'b00, 2);
    sbits(32'd0, 7);
    sclk = 1'b0;
    clk_n(2);
    chk("R12 still busy after ignored lock", {30'd0, oe, dout}, 32'b10);
    for (int i = 0; i < 1000 && dout !== 1'b1; i++) clk_n(1);
    chk("R12 ready after ignored command", 32'(dout), 32'd1);
    cs = 1'b0;
    clk_n(3);
    send_cmd(2'b01, 32'd8, 32'h8888, 1'b1);
    prog_wait("R12 write after busy");
    read_chk("R12 lock during busy ignored", 32'd8, 1, 16'h8888, 16'h0);
    read_chk("R9 earlier write kept", 32'd7, 1, 16'h7777, 16'h0);
  endtask

  task automatic t_lock();
    send_ext(2'b00, 32'd0, 1'b0);
    send_cmd(2'b01, 32'd9, 32'h0000, 1'b1);
    read_chk("R8 lock blocks write", 32'd9, 1, 16'hFFFF, 16'h0);
    send_cmd(2'b11, 32'd8, 32'd0, 1'b0);
    read_chk("R8 lock blocks erase", 32'd8, 1, 16'h8888, 16'h0);
    send_ext(2'b11, 32'd0, 1'b0);
  endtask

  task automatic t_all();
    send_ext(2'b01, 32'h5AA5, 1'b1);
    prog_wait("R10 write-all");
    read_chk("R10 write-all words 0,1", 32'd0, 2, 16'h5AA5, 16'h5AA5);
    read_chk("R10 write-all word 100", 32'd100, 1, 16'h5AA5, 16'h0);
    send_ext(2'b10, 32'd0, 1'b0);
    prog_wait("R10 erase-all");
    read_chk("R10 erase-all", 32'd77, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic t_x8();
    org = 1'b0;
    clk_n(2);
    send_cmd(2'b01, 32'hFF, 32'h81, 1'b1);
    prog_wait("R3 x8 write");
    send_cmd(2'b01, 32'h00, 32'h3C, 1'b1);
    prog_wait("R3 x8 write");
    read_chk("R3 R4 x8 bytes and wrap", 32'hFF, 2, 16'h0081, 16'h003C);
    read_chk("R3 x8 untouched byte", 32'h01, 1, 16'h00FF, 16'h0);
    org = 1'b1;
    clk_n(2);
  endtask

  initial begin
    clk_n(3);
    rst_n = 1'b1;
    clk_n(3);
    t_reset();
    t_start_qual();
    t_protect();
    t_write_read();
    t_seq_wrap();
    t_erase();
    t_trunc();
    t_busy_block();
    t_lock();
    t_all();
    t_x8();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule